// File: doc/BRIEF.md
# Descriptor Ring Packet DMA Engine

This block carries packets between a word-wide packet stream and a shared word-addressed memory. It has one receive queue and one transmit queue. Software builds each queue as a circular chain of four-word descriptors and hands each descriptor to the engine by setting its ownership bit. The engine handles only descriptors it owns. For each frame it places the data in, or takes it from, the single buffer the descriptor points to. It then returns the descriptor to software by clearing the ownership bit.

Each descriptor occupies four consecutive words starting at its base address (addresses count words):

- base+0: command/status word.
- base+1: count word. The high half holds the transmit frame length or the receive buffer size, in bytes. The low half receives the receive frame length.
- base+2: buffer address.
- base+3: address of the next descriptor.

The command/status word uses these bits:

| Bit | Meaning |
|-----|---------|
| 31 | Owned by the engine |
| 23 | Raise an interrupt on completion |
| 22 | Ask for CRC generation (transmit) |
| 19 | Ask for short-frame padding (transmit) |
| 17 | First buffer of the frame |
| 16 | Last buffer of the frame |
| 15 | Error summary (receive) |

Lengths count bytes, and every stream word carries four bytes.

Receive starts with an enable command and stops on an abort command or when the queue runs out of owned descriptors. Transmit starts with a demand command and walks the chain until it reaches a descriptor it does not own. Interrupt causes are sticky, and software clears them by writing zeros to the cause register.

Top module: `dma_ring_engine`

## Requirements
- R1: After reset both pointers are 0. All cause bits are 0. No memory request is made, transmit is not busy and no transmit word is valid.
- R2: An enable command makes receive read the descriptor at the receive pointer. If bit 31 of that descriptor is clear, receive stops there: the pointer stays and that descriptor is never written.
- R3: The words of a received frame go to consecutive buffer words. Word base+1 is then written with the buffer size kept in the high half and the frame length (4 bytes per word) in the low half.
- R4: Word base+1 is written before the status word, and in an earlier, separate write. The status word is then written with bit 31 clear, bits 17 and 16 set, bit 23 kept as read and bit 15 giving the error. After that the receive pointer takes the next-descriptor value. Cause bit 0 is set when bit 23 was set.
- R5: Words beyond the buffer size divided by 4 are not written. A frame that overflows its buffer gets bit 15 set in its status word and sets cause bit 1.
- R6: A frame that starts while receive holds no owned descriptor sets cause bit 3, writes no memory and disables receive. A new enable command fetches the descriptor again.
- R7: A frame that starts while receive is fetching a descriptor or writing one back is dropped, and it sets cause bit 2.
- R8: A demand command makes transmit read the descriptor at the transmit pointer and stream ceil(length/4) words from the buffer. The last output is raised on the final word. The padding and CRC outputs follow bits 19 and 22. The status word is written back with only bit 31 cleared, cause bit 4 is set if bit 23 was set, and the pointer advances. Transmit continues while it owns descriptors and shows busy while active.
- R9: A demand that finds the descriptor at the transmit pointer not owned sets cause bit 6 and streams nothing.
- R10: Receive has priority on the memory port. A transmit read refused in the middle of a frame sets cause bit 5, and the frame still completes with correct data.
- R11: An abort command returns its direction to idle in the next cycle and abandons the descriptor in use, which keeps bit 31 set.
- R12: A cause write keeps only the bits written as 1. A bit that gets set in the same cycle stays set.
- R13: A pointer load is accepted only while its direction is idle or stopped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_en_i | input | 1 | Enable-receive command pulse |
| rx_abort_i | input | 1 | Abort-receive command pulse |
| tx_demand_i | input | 1 | Transmit-demand command pulse |
| tx_abort_i | input | 1 | Abort-transmit command pulse |
| rx_ptr_wr_i | input | 1 | Load the receive pointer |
| rx_ptr_i | input | AW | Receive pointer load value |
| tx_ptr_wr_i | input | 1 | Load the transmit pointer |
| tx_ptr_i | input | AW | Transmit pointer load value |
| rx_cur_ptr_o | output | AW | Current receive descriptor address |
| tx_cur_ptr_o | output | AW | Current transmit descriptor address |
| tx_busy_o | output | 1 | Transmit in progress |
| irq_wr_i | input | 1 | Cause register write strobe |
| irq_wdata_i | input | 7 | Cause write data (0 clears a bit) |
| irq_cause_o | output | 7 | Sticky cause bits |
| rx_valid_i | input | 1 | Receive stream word valid |
| rx_data_i | input | 32 | Receive stream word |
| rx_last_i | input | 1 | Final word of the receive frame |
| tx_valid_o | output | 1 | Transmit stream word valid |
| tx_data_o | output | 32 | Transmit stream word |
| tx_last_o | output | 1 | Final word of the transmit frame |
| tx_pad_o | output | 1 | Padding request for the current frame |
| tx_crc_o | output | 1 | CRC request for the current frame |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | Memory write enable |
| mem_addr_o | output | AW | Memory word address |
| mem_wdata_o | output | 32 | Memory write data |
| mem_rdata_i | input | 32 | Read data, one cycle after the request |

## Verification
The assertions assume that memory always accepts a request and returns read data exactly one cycle later. They also assume that commands are single-cycle pulses and that receive words arrive only as whole frames that end with a last-flagged word. The stimulus meets these assumptions with a one-cycle memory model and by driving every command and stream word for exactly one cycle. Frames are spaced farther apart than a writeback plus the next fetch, except in the overrun case, which deliberately starts a frame during a fetch. Descriptors are written to memory before receive is enabled or transmit is demanded, and the pointers are loaded only while their direction is idle, apart from the single load issued to show that it is ignored.

// File: rtl/dma_ring_pkg.sv
package dma_ring_pkg;
  localparam int DW      = 32;
  localparam int OWN_B   = 31;
  localparam int EI_B    = 23;
  localparam int CRC_B   = 22;
  localparam int PAD_B   = 19;
  localparam int FIRST_B = 17;
  localparam int LAST_B  = 16;
  localparam int ERR_B   = 15;
  localparam int NCAUSE  = 7;
  localparam int C_RX_DONE = 0;
  localparam int C_RX_ERR  = 1;
  localparam int C_RX_OVR  = 2;
  localparam int C_RX_RES  = 3;
  localparam int C_TX_DONE = 4;
  localparam int C_TX_UDR  = 5;
  localparam int C_TX_RES  = 6;
endpackage

// File: rtl/dma_rx_path.sv
module dma_rx_path import dma_ring_pkg::*; #(
  parameter int AW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          abort_i,
  input  logic          ptr_wr_i,
  input  logic [AW-1:0] ptr_i,
  output logic [AW-1:0] cur_ptr_o,
  input  logic          s_valid_i,
  input  logic [DW-1:0] s_data_i,
  input  logic          s_last_i,
  output logic          req_o,
  output logic          we_o,
  output logic [AW-1:0] addr_o,
  output logic [DW-1:0] wdata_o,
  input  logic [DW-1:0] rdata_i,
  output logic          done_o,
  output logic          err_o,
  output logic          ovr_o,
  output logic          res_o
);
  typedef enum logic [3:0] {
    R_OFF, R_F0, R_F1, R_F2, R_F3, R_F4, R_WAIT, R_DATA, R_WB1, R_WB0, R_NOBUF
  } rx_st_e;

  rx_st_e        state;
  logic [AW-1:0] cur, nxt, bufp;
  logic [15:0]   size, cnt;
  logic          ei, err, in_frm;

  logic [15:0] cap_w;
  logic        sof, busy, take, room;
  logic [15:0] wr_off;

  assign cap_w  = {2'b00, size[15:2]};
  assign sof    = s_valid_i && !in_frm;
  assign busy   = state inside {R_F0, R_F1, R_F2, R_F3, R_F4, R_WB1, R_WB0};
  assign take   = (state == R_WAIT && sof) || (state == R_DATA && s_valid_i);
  assign wr_off = (state == R_WAIT) ? 16'd0 : cnt;
  assign room   = wr_off < cap_w;

  assign cur_ptr_o = cur;
  assign done_o    = (state == R_WB0) && ei;
  assign err_o     = (state == R_WB0) && err;
  assign ovr_o     = busy && sof;
  assign res_o     = (state == R_NOBUF) && sof;

  always_comb begin
    req_o   = 1'b0;
    we_o    = 1'b0;
    addr_o  = cur;
    wdata_o = '0;
    unique case (state)
      R_F0: req_o = 1'b1;
      R_F1: if (rdata_i[OWN_B]) begin req_o = 1'b1; addr_o = cur + AW'(1); end
      R_F2: begin req_o = 1'b1; addr_o = cur + AW'(2); end
      R_F3: begin req_o = 1'b1; addr_o = cur + AW'(3); end
      R_WAIT, R_DATA: if (take && room) begin
        req_o = 1'b1; we_o = 1'b1; addr_o = bufp + AW'(wr_off); wdata_o = s_data_i;
      end
      R_WB1: begin
        req_o = 1'b1; we_o = 1'b1; addr_o = cur + AW'(1);
        wdata_o = {size, cnt[13:0], 2'b00};
      end
      R_WB0: begin
        req_o = 1'b1; we_o = 1'b1;
        wdata_o[EI_B]    = ei;
        wdata_o[FIRST_B] = 1'b1;
        wdata_o[LAST_B]  = 1'b1;
        wdata_o[ERR_B]   = err;
      end
      default: ;
    endcase
  end

  // frame boundary tracker, independent of engine state
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) in_frm <= 1'b0;
    else if (s_valid_i) in_frm <= !s_last_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state <= R_OFF;
      cur <= '0; nxt <= '0; bufp <= '0;
      size <= '0; cnt <= '0; ei <= 1'b0; err <= 1'b0;
    end else if (abort_i) begin
      state <= R_OFF;
    end else begin
      unique case (state)
        R_OFF, R_NOBUF: begin
          if (ptr_wr_i) cur <= ptr_i;
          if (en_i) state <= R_F0;
          else if (state == R_NOBUF && sof) state <= R_OFF;
        end
        R_F0: state <= R_F1;
        R_F1: if (rdata_i[OWN_B]) begin
          ei <= rdata_i[EI_B]; state <= R_F2;
        end else state <= R_NOBUF;
        R_F2: begin size <= rdata_i[31:16]; state <= R_F3; end
        R_F3: begin bufp <= rdata_i[AW-1:0]; state <= R_F4; end
        R_F4: begin nxt <= rdata_i[AW-1:0]; state <= R_WAIT; end
        R_WAIT: if (sof) begin
          cnt <= 16'd1;
          err <= (cap_w == 16'd0);
          state <= s_last_i ? R_WB1 : R_DATA;
        end
        R_DATA: if (s_valid_i) begin
          cnt <= cnt + 16'd1;
          if (!room) err <= 1'b1;
          if (s_last_i) state <= R_WB1;
        end
        R_WB1: state <= R_WB0;
        R_WB0: begin cur <= nxt; state <= R_F0; end
        default: state <= R_OFF;
      endcase
    end
  end

  a_r11_rx_abort: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(abort_i) |-> state == R_OFF);
  a_r4_release_after_len: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == R_WB0) |-> $past(state) == R_WB1);
  a_r6_nobuf_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == R_NOBUF) |-> !req_o);
endmodule

// File: rtl/dma_tx_path.sv
module dma_tx_path import dma_ring_pkg::*; #(
  parameter int AW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          demand_i,
  input  logic          abort_i,
  input  logic          ptr_wr_i,
  input  logic [AW-1:0] ptr_i,
  output logic [AW-1:0] cur_ptr_o,
  output logic          busy_o,
  output logic          req_o,
  input  logic          gnt_i,
  output logic          we_o,
  output logic [AW-1:0] addr_o,
  output logic [DW-1:0] wdata_o,
  input  logic [DW-1:0] rdata_i,
  output logic          m_valid_o,
  output logic [DW-1:0] m_data_o,
  output logic          m_last_o,
  output logic          m_pad_o,
  output logic          m_crc_o,
  output logic          done_o,
  output logic          udr_o,
  output logic          res_o
);
  typedef enum logic [2:0] {T_IDLE, T_FREQ, T_FDAT, T_DATA, T_WB} tx_st_e;

  tx_st_e        state;
  logic [AW-1:0] cur, nxt, bufp;
  logic [DW-1:0] cmdw;
  logic [15:0]   nwords, issued;
  logic [1:0]    idx;
  logic          first_run, pend, pend_last;
  logic          more;

  assign more      = issued < nwords;
  assign cur_ptr_o = cur;
  assign busy_o    = state != T_IDLE;
  assign m_valid_o = pend;
  assign m_data_o  = rdata_i;
  assign m_last_o  = pend && pend_last;
  assign m_pad_o   = cmdw[PAD_B];
  assign m_crc_o   = cmdw[CRC_B];
  assign done_o    = (state == T_WB) && gnt_i && cmdw[EI_B];
  assign udr_o     = (state == T_DATA) && more && (issued != 16'd0) && !gnt_i;
  assign res_o     = (state == T_FDAT) && (idx == 2'd0) && !rdata_i[OWN_B] && first_run;

  always_comb begin
    req_o   = 1'b0;
    we_o    = 1'b0;
    addr_o  = cur;
    wdata_o = '0;
    unique case (state)
      T_FREQ: begin req_o = 1'b1; addr_o = cur + AW'(idx); end
      T_DATA: if (more) begin req_o = 1'b1; addr_o = bufp + AW'(issued); end
      T_WB: begin
        req_o = 1'b1; we_o = 1'b1;
        wdata_o = cmdw;
        wdata_o[OWN_B] = 1'b0;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state <= T_IDLE;
      cur <= '0; nxt <= '0; bufp <= '0; cmdw <= '0;
      nwords <= '0; issued <= '0; idx <= '0;
      first_run <= 1'b0; pend <= 1'b0; pend_last <= 1'b0;
    end else if (abort_i) begin
      state <= T_IDLE;
      pend  <= 1'b0;
    end else begin
      pend <= 1'b0;
      unique case (state)
        T_IDLE: begin
          if (ptr_wr_i) cur <= ptr_i;
          if (demand_i) begin state <= T_FREQ; idx <= '0; first_run <= 1'b1; end
        end
        T_FREQ: if (gnt_i) state <= T_FDAT;
        T_FDAT: begin
          state <= T_FREQ;
          idx   <= idx + 2'd1;
          unique case (idx)
            2'd0: if (rdata_i[OWN_B]) cmdw <= rdata_i; else state <= T_IDLE;
            2'd1: nwords <= 16'((17'(rdata_i[31:16]) + 17'd3) >> 2);
            2'd2: bufp <= rdata_i[AW-1:0];
            default: begin nxt <= rdata_i[AW-1:0]; issued <= '0; state <= T_DATA; end
          endcase
        end
        T_DATA: begin
          if (more && gnt_i) begin
            issued    <= issued + 16'd1;
            pend      <= 1'b1;
            pend_last <= (issued == nwords - 16'd1);
          end
          if (!more) state <= T_WB;
        end
        T_WB: if (gnt_i) begin
          cur <= nxt; first_run <= 1'b0; idx <= '0; state <= T_FREQ;
        end
        default: state <= T_IDLE;
      endcase
    end
  end

  a_r8_last_once: assert property (@(posedge clk_i) disable iff (!rst_ni)
    m_last_o |=> !m_valid_o);
  a_r8_stream_from_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    m_valid_o |-> $past(state) == T_DATA);
endmodule

// File: rtl/dma_mem_mux.sv
module dma_mem_mux import dma_ring_pkg::*; #(
  parameter int AW = 16
) (
  input  logic          rx_req_i,
  input  logic          rx_we_i,
  input  logic [AW-1:0] rx_addr_i,
  input  logic [DW-1:0] rx_wdata_i,
  input  logic          tx_req_i,
  input  logic          tx_we_i,
  input  logic [AW-1:0] tx_addr_i,
  input  logic [DW-1:0] tx_wdata_i,
  output logic          tx_gnt_o,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o
);
  // receive cannot stall its stream, so it always wins
  assign tx_gnt_o    = tx_req_i && !rx_req_i;
  assign mem_req_o   = rx_req_i || tx_req_i;
  assign mem_we_o    = rx_req_i ? rx_we_i    : tx_we_i;
  assign mem_addr_o  = rx_req_i ? rx_addr_i  : tx_addr_i;
  assign mem_wdata_o = rx_req_i ? rx_wdata_i : tx_wdata_i;
endmodule

// File: rtl/dma_ring_engine.sv
module dma_ring_engine import dma_ring_pkg::*; #(
  parameter int AW = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rx_en_i,
  input  logic              rx_abort_i,
  input  logic              tx_demand_i,
  input  logic              tx_abort_i,
  input  logic              rx_ptr_wr_i,
  input  logic [AW-1:0]     rx_ptr_i,
  input  logic              tx_ptr_wr_i,
  input  logic [AW-1:0]     tx_ptr_i,
  output logic [AW-1:0]     rx_cur_ptr_o,
  output logic [AW-1:0]     tx_cur_ptr_o,
  output logic              tx_busy_o,
  input  logic              irq_wr_i,
  input  logic [NCAUSE-1:0] irq_wdata_i,
  output logic [NCAUSE-1:0] irq_cause_o,
  input  logic              rx_valid_i,
  input  logic [DW-1:0]     rx_data_i,
  input  logic              rx_last_i,
  output logic              tx_valid_o,
  output logic [DW-1:0]     tx_data_o,
  output logic              tx_last_o,
  output logic              tx_pad_o,
  output logic              tx_crc_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [AW-1:0]     mem_addr_o,
  output logic [DW-1:0]     mem_wdata_o,
  input  logic [DW-1:0]     mem_rdata_i
);
  logic          rx_req, rx_we, tx_req, tx_we, tx_gnt;
  logic [AW-1:0] rx_addr, tx_addr;
  logic [DW-1:0] rx_wdata, tx_wdata;
  logic          rx_done, rx_err, rx_ovr, rx_res, tx_done, tx_udr, tx_res;
  logic [NCAUSE-1:0] cause, cause_set;

  dma_rx_path #(.AW(AW)) u_rx (
    .clk_i, .rst_ni,
    .en_i(rx_en_i), .abort_i(rx_abort_i),
    .ptr_wr_i(rx_ptr_wr_i), .ptr_i(rx_ptr_i), .cur_ptr_o(rx_cur_ptr_o),
    .s_valid_i(rx_valid_i), .s_data_i(rx_data_i), .s_last_i(rx_last_i),
    .req_o(rx_req), .we_o(rx_we), .addr_o(rx_addr), .wdata_o(rx_wdata),
    .rdata_i(mem_rdata_i),
    .done_o(rx_done), .err_o(rx_err), .ovr_o(rx_ovr), .res_o(rx_res)
  );

  dma_tx_path #(.AW(AW)) u_tx (
    .clk_i, .rst_ni,
    .demand_i(tx_demand_i), .abort_i(tx_abort_i),
    .ptr_wr_i(tx_ptr_wr_i), .ptr_i(tx_ptr_i), .cur_ptr_o(tx_cur_ptr_o),
    .busy_o(tx_busy_o),
    .req_o(tx_req), .gnt_i(tx_gnt), .we_o(tx_we), .addr_o(tx_addr),
    .wdata_o(tx_wdata), .rdata_i(mem_rdata_i),
    .m_valid_o(tx_valid_o), .m_data_o(tx_data_o), .m_last_o(tx_last_o),
    .m_pad_o(tx_pad_o), .m_crc_o(tx_crc_o),
    .done_o(tx_done), .udr_o(tx_udr), .res_o(tx_res)
  );

  dma_mem_mux #(.AW(AW)) u_mux (
    .rx_req_i(rx_req), .rx_we_i(rx_we), .rx_addr_i(rx_addr), .rx_wdata_i(rx_wdata),
    .tx_req_i(tx_req), .tx_we_i(tx_we), .tx_addr_i(tx_addr), .tx_wdata_i(tx_wdata),
    .tx_gnt_o(tx_gnt),
    .mem_req_o, .mem_we_o, .mem_addr_o, .mem_wdata_o
  );

  always_comb begin
    cause_set            = '0;
    cause_set[C_RX_DONE] = rx_done;
    cause_set[C_RX_ERR]  = rx_err;
    cause_set[C_RX_OVR]  = rx_ovr;
    cause_set[C_RX_RES]  = rx_res;
    cause_set[C_TX_DONE] = tx_done;
    cause_set[C_TX_UDR]  = tx_udr;
    cause_set[C_TX_RES]  = tx_res;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cause <= '0;
    else cause <= (irq_wr_i ? (cause & irq_wdata_i) : cause) | cause_set;
  end

  assign irq_cause_o = cause;

  a_r12_cause_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(irq_wr_i) |-> (($past(irq_cause_o) & ~irq_cause_o) == '0));
  a_r11_tx_abort: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(tx_abort_i) |-> (!tx_busy_o && !tx_valid_o));
  a_r10_single_owner: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({rx_req, tx_gnt}));
endmodule

// File: tb/sim_dma_ring_engine.sv
`timescale 1ns/1ps
module sim_dma_ring_engine;
  localparam int AW = 16;
  localparam logic [31:0] OWN = 32'h8000_0000, EI = 32'h0080_0000,
                          CRC = 32'h0040_0000, PAD = 32'h0008_0000,
                          FL  = 32'h0003_0000, ERR = 32'h0000_8000;
  // {words, buffer size bytes, 7'b0, irq enable}
  localparam logic [31:0] RXV [4] = '{
    {8'd3, 16'd64, 7'd0, 1'b1},
    {8'd1, 16'd16, 7'd0, 1'b0},
    {8'd6, 16'd16, 7'd0, 1'b1},
    {8'd4, 16'd16, 7'd0, 1'b0}
  };

  logic clk = 0, rst_n = 0;
  always #2 clk = ~clk;

  logic rx_en = 0, rx_abort = 0, tx_demand = 0, tx_abort = 0;
  logic rx_ptr_wr = 0, tx_ptr_wr = 0, irq_wr = 0;
  logic [AW-1:0] rx_ptr = 0, tx_ptr = 0;
  logic [6:0] irq_wdata = 0;
  logic rx_valid = 0, rx_last = 0;
  logic [31:0] rx_data = 0;
  logic [AW-1:0] rx_cur, tx_cur, mem_addr;
  logic tx_busy, tx_valid, tx_last, tx_pad, tx_crc, mem_req, mem_we;
  logic [6:0] cause;
  logic [31:0] tx_data, mem_wdata, rdq;

  dma_ring_engine #(.AW(AW)) u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .rx_en_i(rx_en), .rx_abort_i(rx_abort), .tx_demand_i(tx_demand), .tx_abort_i(tx_abort),
    .rx_ptr_wr_i(rx_ptr_wr), .rx_ptr_i(rx_ptr), .tx_ptr_wr_i(tx_ptr_wr), .tx_ptr_i(tx_ptr),
    .rx_cur_ptr_o(rx_cur), .tx_cur_ptr_o(tx_cur), .tx_busy_o(tx_busy),
    .irq_wr_i(irq_wr), .irq_wdata_i(irq_wdata), .irq_cause_o(cause),
    .rx_valid_i(rx_valid), .rx_data_i(rx_data), .rx_last_i(rx_last),
    .tx_valid_o(tx_valid), .tx_data_o(tx_data), .tx_last_o(tx_last),
    .tx_pad_o(tx_pad), .tx_crc_o(tx_crc),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_rdata_i(rdq)
  );

  logic [31:0] mem [1024];
  int wtime [1024];
  int cyc = 0;
  always @(posedge clk) begin
    cyc = cyc + 1;
    if (mem_req && mem_we) begin
      mem[mem_addr[9:0]] = mem_wdata;
      wtime[mem_addr[9:0]] = cyc;
    end
    if (mem_req && !mem_we) rdq <= mem[mem_addr[9:0]];
  end

  logic [31:0] txw [32];
  logic [2:0]  txf [32];
  int txn = 0;
  always @(negedge clk) if (tx_valid && txn < 32) begin
    txw[txn] = tx_data;
    txf[txn] = {tx_last, tx_pad, tx_crc};
    txn = txn + 1;
  end

  int nchk = 0, nfail = 0;
  bit fin = 0;

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h", r, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(ref logic s);
    @(negedge clk); s = 1; @(negedge clk); s = 0;
  endtask

  task automatic send(input int n, input logic [31:0] base);
    for (int w = 0; w < n; w++) begin
      @(negedge clk);
      rx_valid = 1; rx_data = base + w; rx_last = (w == n - 1);
    end
    @(negedge clk); rx_valid = 0; rx_last = 0;
  endtask

  task automatic irq_write(input logic [6:0] v);
    @(negedge clk); irq_wr = 1; irq_wdata = v; @(negedge clk); irq_wr = 0;
  endtask

  initial begin
    rdq = 0;
    for (int a = 0; a < 1024; a++) begin mem[a] = 0; wtime[a] = 0; end
    for (int a = 'h100; a < 'h200; a++) mem[a] = 32'hDEAD_0000 | a;
    for (int i = 0; i < 4; i++) begin
      mem[4*i]   = OWN | (RXV[i][0] ? EI : 0);
      mem[4*i+1] = {RXV[i][23:8], 16'h0};
      mem[4*i+2] = 32'h100 + 32'h20 * i;
      mem[4*i+3] = (i == 3) ? 0 : 4*i + 4;
    end
    tick(3);
    rst_n = 1;
    tick(1);
    // R1 reset state
    chk("R1 cause", {25'd0, cause}, 0);
    chk("R1 rx ptr", {16'd0, rx_cur}, 0);
    chk("R1 tx ptr", {16'd0, tx_cur}, 0);
    chk("R1 idle", {28'd0, tx_busy, tx_valid, mem_req, 1'b0}, 0);

    pulse(rx_en);
    tick(8);
    for (int i = 0; i < 4; i++) begin
      int nw, sz, cap, st;
      logic e, er;
      nw = RXV[i][31:24]; sz = RXV[i][23:8]; e = RXV[i][0];
      cap = sz / 4; er = nw > cap; st = er ? cap : nw;
      send(nw, 32'hA000_0000 + (i << 8));
      tick(12);
      chk("R3 count word", mem[4*i+1], {sz[15:0], 16'(4*nw)});
      chk("R4 status word", mem[4*i], (e ? EI : 0) | FL | (er ? ERR : 0));
      chk("R4 len before release", {31'd0, wtime[4*i+1] < wtime[4*i]}, 1);
      chk("R4 pointer advance", {16'd0, rx_cur}, (i == 3) ? 0 : 4*i + 4);
      for (int j = 0; j < st; j++)
        chk("R3 buffer data", mem['h100 + 'h20*i + j], 32'hA000_0000 + (i << 8) + j);
      chk("R5 no write past size", mem['h100 + 'h20*i + st], 32'hDEAD_0000 | ('h100 + 'h20*i + st));
      chk("R4/R5 cause", {30'd0, cause[1:0]}, {30'd0, er, e});
      irq_write(7'h00);
    end

    // R2: ring wrapped to descriptor 0, no longer owned
    chk("R2 stopped at unowned", {16'd0, rx_cur}, 0);
    chk("R2 unowned untouched", mem[0], EI | FL);
    // R6 frame with no descriptor
    send(2, 32'h5555_0000);
    tick(4);
    chk("R6 res err", {31'd0, cause[3]}, 1);
    chk("R6 no write", mem[1], {16'd64, 16'd12});
    chk("R6 buffer kept", mem['h100], 32'hA000_0000);
    irq_write(7'h00);
    mem[0] = OWN;
    send(1, 32'h6666_0000);
    tick(4);
    chk("R6 stays off", {31'd0, mem[0][31]}, 1);
    pulse(rx_en);
    tick(8);
    send(1, 32'h7777_0000);
    tick(12);
    chk("R6 reenabled", mem[1], {16'd64, 16'd4});
    chk("R6 data", mem['h100], 32'h7777_0000);

    // R7 overrun: frame starts during fetch of descriptor 1
    irq_write(7'h00);
    mem[4] = OWN;
    @(negedge clk); rx_en = 1;
    @(negedge clk); rx_en = 0; rx_valid = 1; rx_last = 1; rx_data = 32'h0BAD_0001;
    @(negedge clk); rx_valid = 0; rx_last = 0;
    tick(10);
    chk("R7 overrun cause", {31'd0, cause[2]}, 1);
    chk("R7 dropped", mem['h120], 32'hA000_0100);

    // R13 pointer load while receiving is ignored
    @(negedge clk); rx_ptr_wr = 1; rx_ptr = 16'h000C;
    @(negedge clk); rx_ptr_wr = 0;
    send(2, 32'h8888_0000);
    tick(12);
    chk("R13 load ignored", mem[5], {16'd16, 16'd8});
    chk("R13 pointer", {16'd0, rx_cur}, 8);

    // R11 receive abort mid-frame
    mem[8] = OWN;
    pulse(rx_en);
    tick(8);
    @(negedge clk); rx_valid = 1; rx_last = 0; rx_data = 32'h9999_0000;
    @(negedge clk); rx_data = 32'h9999_0001; rx_abort = 1;
    @(negedge clk); rx_abort = 0; rx_data = 32'h9999_0002; rx_last = 1;
    @(negedge clk); rx_valid = 0; rx_last = 0;
    tick(6);
    chk("R11 rx abandoned", mem[8], OWN);
    chk("R11 rx quiet", {31'd0, mem_req}, 0);
    chk("R11 rx ptr held", {16'd0, rx_cur}, 8);

    // R8 transmit two-frame chain
    irq_write(7'h00);
    mem['h40] = OWN | EI | PAD; mem['h41] = {16'd12, 16'h0}; mem['h42] = 'h200; mem['h43] = 'h44;
    mem['h44] = OWN | CRC;      mem['h45] = {16'd6, 16'h0};  mem['h46] = 'h210; mem['h47] = 'h40;
    for (int k = 0; k < 3; k++) mem['h200 + k] = 32'hB000_0000 + k;
    for (int k = 0; k < 2; k++) mem['h210 + k] = 32'hC000_0000 + k;
    @(negedge clk); tx_ptr_wr = 1; tx_ptr = 16'h0040;
    @(negedge clk); tx_ptr_wr = 0;
    txn = 0;
    pulse(tx_demand);
    tick(1);
    chk("R8 busy", {31'd0, tx_busy}, 1);
    tick(40);
    chk("R8 word count", txn, 5);
    for (int k = 0; k < 5; k++) begin
      chk("R8 data", txw[k], (k < 3) ? 32'hB000_0000 + k : 32'hC000_0000 + k - 3);
      chk("R8 last/pad/crc", {29'd0, txf[k]},
          {29'd0, (k == 2 || k == 4), (k < 3), (k >= 3)});
    end
    chk("R8 release 0", mem['h40], EI | PAD);
    chk("R8 release 1", mem['h44], CRC);
    chk("R8 ptr stop", {16'd0, tx_cur}, 'h40);
    chk("R8 done cause", {31'd0, cause[4]}, 1);
    chk("R8 idle", {31'd0, tx_busy}, 0);

    // R9 demand on unowned descriptor
    irq_write(7'h00);
    pulse(tx_demand);
    tick(10);
    chk("R9 res err", {31'd0, cause[6]}, 1);
    chk("R9 no stream", txn, 5);
    irq_write(7'h00);

    // R10 underrun from a receive word stealing the port
    mem['h48] = OWN; mem['h49] = {16'd40, 16'h0}; mem['h4A] = 'h220; mem['h4B] = 'h48;
    for (int k = 0; k < 10; k++) mem['h220 + k] = 32'hE000_0000 + k;
    @(negedge clk); tx_ptr_wr = 1; tx_ptr = 16'h0048;
    @(negedge clk); tx_ptr_wr = 0;
    pulse(rx_en);
    tick(8);
    txn = 0;
    pulse(tx_demand);
    for (int g = 0; g < 40 && !tx_valid; g++) @(negedge clk);
    rx_valid = 1; rx_last = 1; rx_data = 32'h1234_5678;
    @(negedge clk); rx_valid = 0; rx_last = 0;
    tick(40);
    chk("R10 underrun", {31'd0, cause[5]}, 1);
    chk("R10 rx won", mem['h140], 32'h1234_5678);
    chk("R10 words", txn, 10);
    for (int k = 0; k < 10; k++) chk("R10 data", txw[k], 32'hE000_0000 + k);

    // R12 write-zero clear
    irq_write(7'h7F);
    chk("R12 ones keep", {31'd0, cause[5]}, 1);
    irq_write(7'h5F);
    chk("R12 zero clears", {31'd0, cause[5]}, 0);

    // R11 transmit abort
    mem['h48] = OWN;
    @(negedge clk); tx_demand = 1;
    @(negedge clk); tx_demand = 0; tx_abort = 1;
    @(negedge clk); tx_abort = 0;
    tick(5);
    chk("R11 tx idle", {31'd0, tx_busy}, 0);
    chk("R11 tx desc kept", mem['h48], OWN);

    fin = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!fin) begin
      nchk++; nfail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
      $finish;
    end
  end
endmodule